// File: doc/BRIEF.md
# Posted-Write and Prefetch Channel Buffer

This block is the data buffer of one drive channel. It sits between a 32-bit host target port and a 16-bit drive transfer engine. Host writes go into a small write queue and are acknowledged as soon as they enter it. The drive engine then takes the data out in the background as 16-bit words, the low half of each doubleword first.

In the read direction, the buffer fetches drive words ahead of the host. It joins each pair of drive words into one doubleword and queues it. A read burst starts with a strobe that loads a prefetch counter from a programmable sector length, counted in doublewords. Read-ahead stops when that counter reaches zero or when the read queue is full.

Before the host touches a non-data register of the drive, it raises a request. The buffer grants it only when all posted writes have gone out to the drive. In the clock cycle of the grant, it discards all prefetched read data.

Top module: `chanBuffer`

## Requirements
- R1: The write queue holds at most 4 doublewords. `hostWrReady` is low exactly while 4 are held. A write offered then is not taken and stays pending until it is accepted, so no data is lost.
- R2: A host write with `hostWrValid` high and `hostWrReady` high is accepted at that clock edge. `wrCount` shows it in the next cycle.
- R3: `drvWrValid` is high whenever the write queue is not empty. `drvWrData` presents bits 15:0 of the oldest doubleword first and bits 31:16 second. Each `drvWrTake` advances one half, and the second take removes the doubleword.
- R4: The read queue holds at most 4 doublewords. `drvRdWant` is low while 4 are held.
- R5: Of each pair of accepted drive words, the first becomes bits 15:0 and the second becomes bits 31:16 of one read doubleword. `hostRdData` shows the oldest read doubleword while `hostRdAvail` is high, and `hostRdPop` removes it.
- R6: `readStart` loads the prefetch counter from `sectorLen`. Each completed read doubleword decrements the counter. `drvRdWant` is high only while the counter is non-zero, so a `sectorLen` of 0 fetches nothing.
- R7: `readStart` discards all queued read doublewords and any half-received drive word. `rdCount` is 0 in the next cycle.
- R8: `regReady` is high exactly when `regReq` is high and the write queue is empty. At that edge the read queue, the pending half word and the prefetch counter are cleared. This takes priority over `readStart`.
- R9: `wrCount`, `rdCount`, `drvWrValid` and `hostRdAvail` change in the same cycle as the queue pointers they describe.
- R10: After reset both queues are empty, `hostWrReady` is high, and `drvWrValid`, `hostRdAvail` and `drvRdWant` are low.
- R11: The following strobes have no effect: `drvWrTake` with an empty write queue, `hostRdPop` with an empty read queue, and `drvRdPut` while `drvRdWant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrValid | input | 1 | Host offers a posted write |
| hostWrData | input | 32 | Posted write doubleword |
| hostWrReady | output | 1 | Write queue has room |
| hostRdPop | input | 1 | Host consumes the head read doubleword |
| hostRdData | output | 32 | Head read doubleword |
| hostRdAvail | output | 1 | Read queue not empty |
| readStart | input | 1 | Start of a new read burst |
| sectorLen | input | 8 | Prefetch length in doublewords |
| regReq | input | 1 | Host wants a non-data register access |
| regReady | output | 1 | Writes drained; read data is invalidated at this edge |
| drvWrValid | output | 1 | A drive write word is available |
| drvWrData | output | 16 | Drive write word |
| drvWrTake | input | 1 | Drive engine consumes the write word |
| drvRdWant | output | 1 | Buffer wants more drive read words |
| drvRdData | input | 16 | Drive read word |
| drvRdPut | input | 1 | Drive read word is valid |
| wrCount | output | 3 | Doublewords in the write queue |
| rdCount | output | 3 | Doublewords in the read queue |

## Verification
The hardest case to reach is a flush or burst restart that lands while a read doubleword is half received. The same case matters when posted writes still block the grant for several cycles. The stimulus runs phases with different strobe densities. In some phases drive takes are rare while register requests and burst restarts are frequent. In others, short sector lengths meet a host that seldom pops, which forces full-queue stalls and the counter running out. A behavioural queue model is compared with every output on every cycle.

// File: rtl/chanBufferPkg.sv
package chanBufferPkg;
  localparam int BUF_DEPTH = 4;
  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  typedef struct packed {
    logic             wrPush;
    logic [PTR_W-1:0] wrPushIdx;
    logic [PTR_W-1:0] wrHeadIdx;
    logic             wrHiSel;
    logic             rdLowLatch;
    logic             rdPush;
    logic [PTR_W-1:0] rdPushIdx;
    logic [PTR_W-1:0] rdHeadIdx;
  } bufStrobeT;
endpackage

// File: rtl/chanBufferCtrl.sv
module chanBufferCtrl
  import chanBufferPkg::*;
#(
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrValid,
  output logic             hostWrReady,
  input  logic             hostRdPop,
  output logic             hostRdAvail,
  input  logic             readStart,
  input  logic [SEC_W-1:0] sectorLen,
  input  logic             regReq,
  output logic             regReady,
  output logic             drvWrValid,
  input  logic             drvWrTake,
  output logic             drvRdWant,
  input  logic             drvRdPut,
  output logic [CNT_W-1:0] wrCount,
  output logic [CNT_W-1:0] rdCount,
  output bufStrobeT        strobe
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_DEPTH);

  logic [PTR_W-1:0] wrWp, wrRp, rdWp, rdRp;
  logic [CNT_W-1:0] wrCnt, rdCnt;
  logic             wrHalf, rdHalf;
  logic [SEC_W-1:0] pfLeft;

  logic wrPushOk, wrTakeOk, wrPopOk;
  logic flush, rdClear, rdPutOk, rdPushOk, rdPopOk;

  assign hostWrReady = (wrCnt != FULL_CNT);
  assign drvWrValid  = (wrCnt != '0);
  assign hostRdAvail = (rdCnt != '0);
  assign drvRdWant   = (pfLeft != '0) && (rdCnt != FULL_CNT);
  assign regReady    = regReq && (wrCnt == '0);
  assign wrCount     = wrCnt;
  assign rdCount     = rdCnt;

  assign wrPushOk = hostWrValid && hostWrReady;
  assign wrTakeOk = drvWrTake && drvWrValid;
  assign wrPopOk  = wrTakeOk && wrHalf;

  assign flush    = regReady;
  assign rdClear  = flush || readStart;
  assign rdPutOk  = drvRdPut && drvRdWant && !rdClear;
  assign rdPushOk = rdPutOk && rdHalf;
  assign rdPopOk  = hostRdPop && hostRdAvail && !rdClear;

  always_comb begin
    strobe            = '0;
    strobe.wrPush     = wrPushOk;
    strobe.wrPushIdx  = wrWp;
    strobe.wrHeadIdx  = wrRp;
    strobe.wrHiSel    = wrHalf;
    strobe.rdLowLatch = rdPutOk && !rdHalf;
    strobe.rdPush     = rdPushOk;
    strobe.rdPushIdx  = rdWp;
    strobe.rdHeadIdx  = rdRp;
  end

  // write side pointers and count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrWp   <= '0;
      wrRp   <= '0;
      wrCnt  <= '0;
      wrHalf <= 1'b0;
    end else begin
      if (wrPushOk) wrWp <= wrWp + 1'b1;
      if (wrTakeOk) wrHalf <= !wrHalf;
      if (wrPopOk)  wrRp <= wrRp + 1'b1;
      wrCnt <= wrCnt + CNT_W'(wrPushOk) - CNT_W'(wrPopOk);
    end
  end

  // read side pointers, count and prefetch counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWp   <= '0;
      rdRp   <= '0;
      rdCnt  <= '0;
      rdHalf <= 1'b0;
      pfLeft <= '0;
    end else if (rdClear) begin
      rdWp   <= '0;
      rdRp   <= '0;
      rdCnt  <= '0;
      rdHalf <= 1'b0;
      pfLeft <= flush ? '0 : sectorLen;
    end else begin
      if (rdPutOk)  rdHalf <= !rdHalf;
      if (rdPushOk) begin
        rdWp   <= rdWp + 1'b1;
        pfLeft <= pfLeft - 1'b1;
      end
      if (rdPopOk) rdRp <= rdRp + 1'b1;
      rdCnt <= rdCnt + CNT_W'(rdPushOk) - CNT_W'(rdPopOk);
    end
  end
endmodule

// File: rtl/chanBufferData.sv
module chanBufferData
  import chanBufferPkg::*;
#(
  parameter int HOST_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  bufStrobeT           strobe,
  input  logic [HOST_W-1:0]   hostWrData,
  output logic [HOST_W-1:0]   hostRdData,
  output logic [HOST_W/2-1:0] drvWrData,
  input  logic [HOST_W/2-1:0] drvRdData
);
  localparam int DRV_W = HOST_W / 2;

  logic [HOST_W-1:0] wrMem [BUF_DEPTH];
  logic [HOST_W-1:0] rdMem [BUF_DEPTH];
  logic [DRV_W-1:0]  rdLow;
  logic [HOST_W-1:0] wrHead;

  genvar gi;
  generate
    for (gi = 0; gi < BUF_DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strobe.wrPush && strobe.wrPushIdx == PTR_W'(gi))
          wrMem[gi] <= hostWrData;
        if (strobe.rdPush && strobe.rdPushIdx == PTR_W'(gi))
          rdMem[gi] <= {drvRdData, rdLow};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                  rdLow <= '0;
    else if (strobe.rdLowLatch) rdLow <= drvRdData;
  end

  assign wrHead     = wrMem[strobe.wrHeadIdx];
  assign drvWrData  = strobe.wrHiSel ? wrHead[HOST_W-1:DRV_W] : wrHead[DRV_W-1:0];
  assign hostRdData = rdMem[strobe.rdHeadIdx];
endmodule

// File: rtl/chanBuffer.sv
module chanBuffer
  import chanBufferPkg::*;
#(
  parameter int HOST_W = 32,
  parameter int SEC_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrValid,
  input  logic [HOST_W-1:0]   hostWrData,
  output logic                hostWrReady,
  input  logic                hostRdPop,
  output logic [HOST_W-1:0]   hostRdData,
  output logic                hostRdAvail,
  input  logic                readStart,
  input  logic [SEC_W-1:0]    sectorLen,
  input  logic                regReq,
  output logic                regReady,
  output logic                drvWrValid,
  output logic [HOST_W/2-1:0] drvWrData,
  input  logic                drvWrTake,
  output logic                drvRdWant,
  input  logic [HOST_W/2-1:0] drvRdData,
  input  logic                drvRdPut,
  output logic [CNT_W-1:0]    wrCount,
  output logic [CNT_W-1:0]    rdCount
);
  bufStrobeT strobe;

  chanBufferCtrl #(.SEC_W(SEC_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWrValid(hostWrValid), .hostWrReady(hostWrReady),
    .hostRdPop(hostRdPop), .hostRdAvail(hostRdAvail),
    .readStart(readStart), .sectorLen(sectorLen),
    .regReq(regReq), .regReady(regReady),
    .drvWrValid(drvWrValid), .drvWrTake(drvWrTake),
    .drvRdWant(drvRdWant), .drvRdPut(drvRdPut),
    .wrCount(wrCount), .rdCount(rdCount),
    .strobe(strobe)
  );

  chanBufferData #(.HOST_W(HOST_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .drvWrData(drvWrData), .drvRdData(drvRdData)
  );
endmodule

// File: rtl/chanBufferChecker.sv
module chanBufferChecker
  import chanBufferPkg::*;
#(
  parameter int SEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWrValid,
  input logic             hostWrReady,
  input logic             readStart,
  input logic [SEC_W-1:0] sectorLen,
  input logic             regReq,
  input logic             regReady,
  input logic             drvRdWant,
  input logic [CNT_W-1:0] wrCount,
  input logic [CNT_W-1:0] rdCount
);
  AST_WR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    wrCount <= CNT_W'(BUF_DEPTH)); // R1
  AST_WR_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount == CNT_W'(BUF_DEPTH)) |-> !hostWrReady); // R1
  AST_WR_ACCEPT_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrValid && hostWrReady) |=> (wrCount != '0)); // R2
  AST_RD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rdCount <= CNT_W'(BUF_DEPTH)); // R4
  AST_RD_FULL_NO_WANT: assert property (@(posedge clk) disable iff (!rstN)
    (rdCount == CNT_W'(BUF_DEPTH)) |-> !drvRdWant); // R4
  AST_ZERO_SECTOR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (readStart && sectorLen == '0) |=> !drvRdWant); // R6
  AST_START_DISCARDS: assert property (@(posedge clk) disable iff (!rstN)
    readStart |=> (rdCount == '0)); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    regReady |=> (rdCount == '0 && !drvRdWant)); // R8
  AST_GRANT_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    regReady |-> (regReq && wrCount == '0)); // R8
endmodule

bind chanBuffer chanBufferChecker #(.SEC_W(SEC_W)) i_chk (
  .clk(clk), .rstN(rstN), .hostWrValid(hostWrValid), .hostWrReady(hostWrReady),
  .readStart(readStart), .sectorLen(sectorLen), .regReq(regReq),
  .regReady(regReady), .drvRdWant(drvRdWant), .wrCount(wrCount), .rdCount(rdCount)
);

// File: tb/test_chanBuffer.sv
module test_chanBuffer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWrValid, hostRdPop, readStart, regReq, drvWrTake, drvRdPut;
  logic [31:0] hostWrData, hostRdData;
  logic [7:0]  sectorLen;
  logic [15:0] drvWrData, drvRdData;
  logic        hostWrReady, hostRdAvail, regReady, drvWrValid, drvRdWant;
  logic [2:0]  wrCount, rdCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chanBuffer i_chanBuffer (
    .clk(clk), .rstN(rstN),
    .hostWrValid(hostWrValid), .hostWrData(hostWrData), .hostWrReady(hostWrReady),
    .hostRdPop(hostRdPop), .hostRdData(hostRdData), .hostRdAvail(hostRdAvail),
    .readStart(readStart), .sectorLen(sectorLen),
    .regReq(regReq), .regReady(regReady),
    .drvWrValid(drvWrValid), .drvWrData(drvWrData), .drvWrTake(drvWrTake),
    .drvRdWant(drvRdWant), .drvRdData(drvRdData), .drvRdPut(drvRdPut),
    .wrCount(wrCount), .rdCount(rdCount)
  );

  // behavioural reference state
  logic [31:0] wrQ[$];
  logic [31:0] rdQ[$];
  bit          wrHi, rdHi;
  logic [15:0] rdLo;
  int          pf;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R1 hostWrReady", 32'(hostWrReady), 32'(wrQ.size() < 4));
    chk("R9 wrCount", 32'(wrCount), 32'(wrQ.size()));
    chk("R9 rdCount", 32'(rdCount), 32'(rdQ.size()));
    chk("R3 drvWrValid", 32'(drvWrValid), 32'(wrQ.size() != 0));
    chk("R9 hostRdAvail", 32'(hostRdAvail), 32'(rdQ.size() != 0));
    chk("R6 drvRdWant", 32'(drvRdWant), 32'(pf != 0 && rdQ.size() < 4));
    chk("R8 regReady", 32'(regReady), 32'(regReq && wrQ.size() == 0));
    if (wrQ.size() != 0)
      chk("R3 drvWrData", 32'(drvWrData), 32'(wrHi ? wrQ[0][31:16] : wrQ[0][15:0]));
    if (rdQ.size() != 0)
      chk("R5 hostRdData", hostRdData, rdQ[0]);
  endtask

  task automatic advanceModel();
    int  wSize = wrQ.size();
    int  rSize = rdQ.size();
    bit  flushNow = regReq && (wSize == 0);
    if (drvWrTake && wSize != 0) begin
      if (!wrHi) wrHi = 1;
      else begin wrHi = 0; void'(wrQ.pop_front()); end
    end
    if (hostWrValid && wSize < 4) wrQ.push_back(hostWrData);
    if (flushNow || readStart) begin
      rdQ.delete();
      rdHi = 0;
      pf = flushNow ? 0 : int'(sectorLen);
    end else begin
      bit putOk = drvRdPut && pf != 0 && rSize < 4;
      if (hostRdPop && rSize != 0) void'(rdQ.pop_front());
      if (putOk) begin
        if (!rdHi) begin rdLo = drvRdData; rdHi = 1; end
        else begin rdQ.push_back({drvRdData, rdLo}); rdHi = 0; pf--; end
      end
    end
  endtask

  task automatic runPhase(input int cycles, input int pW, input int pT, input int pP,
                          input int pR, input int pS, input int pQ, input int maxSec);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compareAll();
      hostWrValid = ($urandom_range(99) < pW);
      hostWrData  = $urandom;
      drvWrTake   = ($urandom_range(99) < pT);
      drvRdPut    = ($urandom_range(99) < pP);
      drvRdData   = 16'($urandom);
      hostRdPop   = ($urandom_range(99) < pR);
      readStart   = ($urandom_range(99) < pS);
      sectorLen   = 8'($urandom_range(maxSec));
      regReq      = ($urandom_range(99) < pQ);
      advanceModel();
    end
  endtask

  initial begin
    rstN = 1'b0;
    hostWrValid = 0; hostWrData = '0; drvWrTake = 0; drvRdPut = 0; drvRdData = '0;
    hostRdPop = 0; readStart = 0; sectorLen = '0; regReq = 0;
    wrHi = 0; rdHi = 0; rdLo = '0; pf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    chk("R10 hostWrReady", 32'(hostWrReady), 32'd1);
    chk("R10 drvWrValid", 32'(drvWrValid), 32'd0);
    chk("R10 hostRdAvail", 32'(hostRdAvail), 32'd0);
    chk("R10 drvRdWant", 32'(drvRdWant), 32'd0);
    // R11: strobes on empty queues and without prefetch have no effect
    drvWrTake = 1; hostRdPop = 1; drvRdPut = 1;
    advanceModel();
    // R1 R2: fill the write queue with the drive stalled
    runPhase(40, 90, 5, 0, 0, 0, 0, 0);
    // R3: drain writes, low half first
    runPhase(40, 10, 90, 0, 0, 0, 0, 0);
    // R4 R6: prefetch with a host that rarely pops
    runPhase(300, 0, 0, 80, 5, 2, 0, 9);
    // R5 R7: restarts that land mid doubleword
    runPhase(400, 0, 0, 70, 40, 15, 0, 5);
    // R8: flush requests while writes are pending and reads are in flight
    runPhase(600, 50, 20, 60, 30, 5, 20, 8);
    // R9 R11: mixed traffic
    runPhase(2000, 40, 50, 50, 50, 4, 5, 12);
    @(negedge clk);
    compareAll();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule